// File: doc/BRIEF.md
# Auto-Reload Decrementer

This block is a 32-bit down-counter advanced by a time-base tick input. Each tick lowers the counter by one. When a tick arrives while the counter holds 1, the block raises an expiry event. If auto-reload is enabled, that same tick loads the counter from a reload register, which gives a period of exactly the reload value in ticks. If auto-reload is disabled, the counter goes to 0 and stays there.

Software reaches the block through simple write ports. There is one port each for the counter, the reload value and a two-bit control word. A single write-1-to-clear strobe serves the expiry flag. The interrupt request is the sticky expiry flag gated by the interrupt enable. It stays high until software clears the flag.

Top module: `dec_timer`

## Requirements
- R1: After reset the counter, the reload value, both control bits, the flag and the interrupt request are all 0.
- R2: On a tick while the counter is greater than 1, the counter decreases by exactly one on the next clock edge.
- R3: On a tick while the counter is 1 and auto-reload is enabled (control bit 1 = 1), the counter takes the reload value instead of 0.
- R4: On a tick while the counter is 1 and auto-reload is disabled, the counter becomes 0. Further ticks leave it at 0 until software writes it.
- R5: A tick while the counter is 0 leaves the counter unchanged and does not set the flag.
- R6: The flag is set at every tick on which the counter leaves the value 1, whether it reloads or goes to 0.
- R7: The flag is cleared only by a clear strobe whose data bit is 1. A strobe with data 0 leaves it unchanged. A flag-setting event in the same cycle as a clear wins.
- R8: A software write to the counter takes priority over a decrement or reload in the same cycle. No flag is set by that tick.
- R9: The interrupt request equals the flag ANDed with the interrupt enable (control bit 0) and stays high until the flag is cleared.
- R10: Writes to the reload register and to the control register take effect on the next clock edge and are read back on their output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick, one count per cycle high |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 32 | Counter write data |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | 32 | Reload register write data |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | Control data: bit 0 interrupt enable, bit 1 auto-reload enable |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_wdata | input | 1 | 1 clears the flag, 0 does nothing |
| cnt | output | 32 | Current counter value |
| rld | output | 32 | Reload value |
| ctl | output | 2 | Control value |
| flag | output | 1 | Expiry status flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench first runs directed patterns. With auto-reload on, a counter set to 1 shows the reload value replacing the counter. With auto-reload off, the same setting shows the counter stopping at 0 and ignoring later ticks. A counter write coinciding with a tick at 1 shows whether the write wins and whether a spurious flag appears. A clear strobe with data 0 shows that zero writes do nothing, and a clear landing on an expiry shows which of the two wins. A long seeded random run then mixes ticks, writes and clears with small counter and reload values, so that expiries happen often. A cycle-accurate model in bench functions tracks it, comparing the counter, the flag and the request every cycle.

// File: rtl/dec_timer.sv
module dec_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_we,
  input  logic [W-1:0] rld_wdata,
  input  logic         ctl_we,
  input  logic [1:0]   ctl_wdata,
  input  logic         flag_clr_we,
  input  logic         flag_clr_wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld,
  output logic [1:0]   ctl,
  output logic         flag,
  output logic         irq
);
  localparam logic [W-1:0] ONE = W'(1);

  logic at_one, expire, arm;

  assign at_one = (cnt == ONE);
  assign expire = tick && at_one && !cnt_we;
  assign arm    = ctl[1];
  assign irq    = flag && ctl[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_we) begin
      cnt <= cnt_wdata;
    end else if (tick && cnt != '0) begin
      if (at_one && arm) cnt <= rld;
      else               cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rld <= '0;
    else if (rld_we) rld <= rld_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl <= '0;
    else if (ctl_we) ctl <= ctl_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             flag <= 1'b0;
    else if (expire)                        flag <= 1'b1;
    else if (flag_clr_we && flag_clr_wdata) flag <= 1'b0;
  end
endmodule

module dec_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_we,
  input logic [W-1:0] cnt_wdata,
  input logic [W-1:0] rld,
  input logic [1:0]   ctl,
  input logic         flag_clr_we,
  input logic         flag_clr_wdata,
  input logic [W-1:0] cnt,
  input logic         flag,
  input logic         irq
);
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt > W'(1)) |=> cnt == $past(cnt) - W'(1)); // R2
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt == W'(1) && ctl[1]) |=> cnt == $past(rld)); // R3
  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt == W'(1) && !ctl[1]) |=> cnt == '0); // R4
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && cnt == '0) |=> cnt == '0); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt == W'(1)) |=> flag); // R6
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(flag_clr_we && flag_clr_wdata)) |=> flag); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt == $past(cnt_wdata)); // R8
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (flag && ctl[0])); // R9
endmodule

bind dec_timer dec_timer_chk #(.W(W)) chk_i (.*);

// File: tb/dec_timer_tb.sv
module dec_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic tick = 0, cnt_we = 0, rld_we = 0, ctl_we = 0, flag_clr_we = 0, flag_clr_wdata = 0;
  logic [31:0] cnt_wdata = 0, rld_wdata = 0;
  logic [1:0] ctl_wdata = 0;
  logic [31:0] cnt, rld;
  logic [1:0] ctl;
  logic flag, irq;
  int total = 0, bad = 0;
  logic [31:0] m_cnt = 0, m_rld = 0;
  logic [1:0] m_ctl = 0;
  logic m_flag = 0;

  always #4 clk = ~clk;

  dec_timer dut_i (.*);

  function automatic logic [31:0] nxt_cnt(logic [31:0] c, logic [31:0] r, logic ar,
                                          logic t, logic we, logic [31:0] wd);
    if (we) return wd;
    if (!t || c == 0) return c;
    if (c == 1 && ar) return r;
    return c - 1;
  endfunction

  function automatic logic nxt_flag(logic f, logic [31:0] c, logic t, logic we,
                                    logic cw, logic cd);
    if (t && c == 1 && !we) return 1'b1;
    if (cw && cd) return 1'b0;
    return f;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    m_flag = nxt_flag(m_flag, m_cnt, tick, cnt_we, flag_clr_we, flag_clr_wdata);
    m_cnt  = nxt_cnt(m_cnt, m_rld, m_ctl[1], tick, cnt_we, cnt_wdata);
    if (rld_we) m_rld = rld_wdata;
    if (ctl_we) m_ctl = ctl_wdata;
    @(posedge clk); #2;
    tick = 0; cnt_we = 0; rld_we = 0; ctl_we = 0; flag_clr_we = 0; flag_clr_wdata = 0;
  endtask

  task automatic cmp(string tag);
    chk({tag, " cnt"}, cnt, m_cnt);
    chk({tag, " flag"}, {31'b0, flag}, {31'b0, m_flag});
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, m_flag & m_ctl[0]});
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 7;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    chk("R1 cnt", cnt, 0); chk("R1 rld", rld, 0); chk("R1 ctl", {30'b0, ctl}, 0);
    chk("R1 flag", {31'b0, flag}, 0); chk("R1 irq", {31'b0, irq}, 0);
    // R10 config
    rld_we = 1; rld_wdata = 5; ctl_we = 1; ctl_wdata = 2'b11; step();
    chk("R10 rld", rld, 5); chk("R10 ctl", {30'b0, ctl}, 3);
    // R2 decrement
    cnt_we = 1; cnt_wdata = 3; step();
    tick = 1; step(); chk("R2", cnt, 2); cmp("R2");
    tick = 1; step(); tick = 1; step();
    chk("R3 reload", cnt, 5); chk("R6 flag", {31'b0, flag}, 1); chk("R9 irq", {31'b0, irq}, 1);
    // R7 clear with 0
    flag_clr_we = 1; flag_clr_wdata = 0; step(); chk("R7 zero", {31'b0, flag}, 1);
    flag_clr_we = 1; flag_clr_wdata = 1; step(); chk("R7 clear", {31'b0, flag}, 0);
    // R9 gate off
    ctl_we = 1; ctl_wdata = 2'b00; step();
    cnt_we = 1; cnt_wdata = 1; step();
    tick = 1; step(); chk("R4 zero", cnt, 0); chk("R6 flag2", {31'b0, flag}, 1);
    chk("R9 gated", {31'b0, irq}, 0);
    flag_clr_we = 1; flag_clr_wdata = 1; step();
    tick = 1; step(); tick = 1; step();
    chk("R5 hold", cnt, 0); chk("R5 noflag", {31'b0, flag}, 0);
    // R8 write wins
    cnt_we = 1; cnt_wdata = 1; step();
    tick = 1; cnt_we = 1; cnt_wdata = 9; step();
    chk("R8 cnt", cnt, 9); chk("R8 flag", {31'b0, flag}, 0);
    // R7 set beats clear
    cnt_we = 1; cnt_wdata = 1; step();
    tick = 1; flag_clr_we = 1; flag_clr_wdata = 1; step();
    chk("R7 set wins", {31'b0, flag}, 1);
    // random
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 100;
      tick = ($urandom % 3) != 0;
      if (r < 8) begin cnt_we = 1; cnt_wdata = $urandom % 6; end
      if (r >= 8 && r < 12) begin rld_we = 1; rld_wdata = $urandom % 6; end
      if (r >= 12 && r < 16) begin ctl_we = 1; ctl_wdata = 2'($urandom); end
      if (r >= 16 && r < 24) begin flag_clr_we = 1; flag_clr_wdata = 1'($urandom); end
      step();
      cmp("R2 R3 R4 R6 R9 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule